// File: doc/BRIEF.md
# Staged System Reset Sequencer

This block merges five reset requests into four reset outputs that let go one after another, each after a counted hold. Power-on reset and an external reset pin may change at any time. Software reset, watchdog time-out and watchdog loss-of-reference are produced by logic clocked on the system clock. Every output asserts at once, with no clock, whenever a source that reaches it is active. It lets go only through a two-flop synchronizer followed by a delay counter on its own counting clock.

The first two stages count on the oscillator clock, because the system clock is not guaranteed during that phase. These are the stretched power-on reset and the clock-generator reset. The peripheral and core stages count on the system clock. Only power-on reset reaches the stretched power-on stage and a separate test-access reset output. A cause register reports what started the most recent reset sequence.

Top module: `rst_seq_top`

## Requirements
- R1: While por_ni is low, all five reset outputs (xpor_rst_no, cgen_rst_no, peri_rst_no, core_rst_no, tap_rst_no) are low without waiting for a clock edge, and cause_o reads 0 (power-on).
- R2: xpor_rst_no rises on the 64th rising edge of osc_clk_i after por_ni rises.
- R3: cgen_rst_no rises on the 32nd rising osc_clk_i edge after the last of these has released: xpor_rst_no, ext_rst_ni and the three synchronous requests.
- R4: peri_rst_no rises on the 32nd rising sys_clk_i edge after cgen_rst_no rises, whatever the ratio of sys_clk_i to osc_clk_i.
- R5: core_rst_no rises on the 32nd rising sys_clk_i edge after peri_rst_no rises.
- R6: A low ext_rst_ni or a high sw_rst_i, wdt_tmo_i or wdt_lor_i drives cgen_rst_no, peri_rst_no and core_rst_no low at once, and leaves xpor_rst_no and tap_rst_no high.
- R7: tap_rst_no rises on the 2nd rising osc_clk_i edge after por_ni rises, and no other source affects it.
- R8: A request that arrives during a countdown restarts the sequence from the earliest stage it reaches, and outputs that had already released go low again. A power-on reset during the stretched-POR count restarts that count from the new release.
- R9: cause_o changes only on the first osc_clk_i edge after cgen_rst_no rises. It is then loaded with the request seen since the previous update, coded 1 external, 2 software, 3 watchdog time-out and 4 loss-of-reference. When several requests were seen, the order of precedence is 1, 3, 4, 2. It is loaded with 0 when none was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock, counts the first two stages |
| sys_clk_i | input | 1 | System clock, counts the last two stages |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset request, active high |
| wdt_tmo_i | input | 1 | Watchdog time-out request, active high |
| wdt_lor_i | input | 1 | Watchdog loss-of-reference request, active high |
| xpor_rst_no | output | 1 | Stretched power-on reset, active low |
| cgen_rst_no | output | 1 | Clock-generator reset, active low |
| peri_rst_no | output | 1 | Peripheral reset, active low |
| core_rst_no | output | 1 | Core reset, active low |
| tap_rst_no | output | 1 | Test-access reset, active low |
| cause_o | output | 3 | Cause of the last reset sequence |

## Verification
The hardest case to reach is a watchdog pulse that lands while the peripheral stage is counting on the system clock. That stage has already been let go by the clock-generator stage. The bench waits until it sees cgen_rst_no rise at the port, lets a few system-clock edges pass, then pulses the request and checks that both downstream outputs drop and later count out in full again. A second hard case holds the external pin low across the stretched-POR release. The bench does this to show that the clock-generator count starts from the later release and that the cause register still records the pin. Every table entry runs at its own system-clock period, so the stage counts are checked with the system clock both faster and slower than the oscillator.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int unsigned NSRC    = 4;
  localparam int unsigned SRC_EXT = 0;
  localparam int unsigned SRC_SW  = 1;
  localparam int unsigned SRC_TMO = 2;
  localparam int unsigned SRC_LOR = 3;

  typedef enum logic [2:0] {
    CAUSE_POR     = 3'd0,
    CAUSE_EXT     = 3'd1,
    CAUSE_SW      = 3'd2,
    CAUSE_WDT_TMO = 3'd3,
    CAUSE_WDT_LOR = 3'd4
  } cause_e;

  // Precedence: external pin, watchdog time-out, loss-of-reference, software.
  function automatic cause_e pick_cause(input logic [NSRC-1:0] seen);
    cause_e c;
    c = CAUSE_POR;
    if (seen[SRC_SW])       c = CAUSE_SW;
    if (seen[SRC_LOR])      c = CAUSE_WDT_LOR;
    if (seen[SRC_TMO])      c = CAUSE_WDT_TMO;
    if (seen[SRC_EXT])      c = CAUSE_EXT;
    return c;
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
// Two-flop reset synchronizer: asserts at once, releases on the 2nd edge.
module rst_seq_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rel_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rel_no = s2_q;
endmodule

// File: rtl/rst_seq_stage.sv
// One reset stage: asserts with arst_ni, releases on the DELAY-th clk_i
// edge after arst_ni rises (two synchronizer edges included). DELAY >= 4.
module rst_seq_stage #(
  parameter int unsigned DELAY = 32
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rel_no
);
  localparam int unsigned    CW   = $clog2(DELAY);
  localparam logic [CW-1:0]  LAST = CW'(DELAY - 3);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = s2_q & ~rel_q;
    cnt_d  = cnt_q + CW'(1);
    rel_d  = rel_q | (cnt_en & (cnt_q == LAST));
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      s1_q  <= 1'b1;
      s2_q  <= s1_q;
      rel_q <= rel_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rel_no = rel_q;

  // Once released, a stage stays released until its input asserts (R8).
  assert_rel_hold_R8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rel_q |=> rel_q);

  // The counter never runs while the synchronizer is still settling (R3).
  assert_cnt_idle_R3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !s2_q |-> (cnt_q == '0));
endmodule

// File: rtl/rst_seq_cause.sv
// Records which requests started the current sequence and commits the cause
// on the first oscillator edge after the clock-generator stage releases.
module rst_seq_cause
  import rst_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            por_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            cgen_rel_ni,
  output cause_e          cause_o
);
  logic [NSRC-1:0] seen;
  logic            done_q;
  logic            commit;
  cause_e          cause_q, cause_d;

  assign commit = cgen_rel_ni & ~done_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_seen
    logic q;
    always_ff @(posedge clk_i or negedge por_ni or posedge src_i[g]) begin
      if (!por_ni)       q <= 1'b0;
      else if (src_i[g]) q <= 1'b1;
      else if (commit)   q <= 1'b0;
    end
    assign seen[g] = q;
  end

  always_ff @(posedge clk_i or negedge cgen_rel_ni) begin
    if (!cgen_rel_ni) done_q <= 1'b0;
    else              done_q <= 1'b1;
  end

  always_comb cause_d = pick_cause(seen);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     cause_q <= CAUSE_POR;
    else if (commit) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  assert_cause_hold_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    !commit |=> $stable(cause_q));

  assert_commit_once_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    commit |=> !commit);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned XPOR_DLY = 64,
  parameter int unsigned CGEN_DLY = 32,
  parameter int unsigned PERI_DLY = 32,
  parameter int unsigned CORE_DLY = 32
) (
  input  logic       osc_clk_i,
  input  logic       sys_clk_i,
  input  logic       por_ni,
  input  logic       ext_rst_ni,
  input  logic       sw_rst_i,
  input  logic       wdt_tmo_i,
  input  logic       wdt_lor_i,
  output logic       xpor_rst_no,
  output logic       cgen_rst_no,
  output logic       peri_rst_no,
  output logic       core_rst_no,
  output logic       tap_rst_no,
  output logic [2:0] cause_o
);
  logic [NSRC-1:0] req;
  logic            cgen_arst_n;
  cause_e          cause;

  always_comb begin
    req          = '0;
    req[SRC_EXT] = ~ext_rst_ni;
    req[SRC_SW]  = sw_rst_i;
    req[SRC_TMO] = wdt_tmo_i;
    req[SRC_LOR] = wdt_lor_i;
  end

  assign cgen_arst_n = por_ni & xpor_rst_no & ~(|req);

  rst_seq_stage #(.DELAY(XPOR_DLY)) u_xpor (
    .clk_i(osc_clk_i), .arst_ni(por_ni), .rel_no(xpor_rst_no));

  rst_seq_stage #(.DELAY(CGEN_DLY)) u_cgen (
    .clk_i(osc_clk_i), .arst_ni(cgen_arst_n), .rel_no(cgen_rst_no));

  rst_seq_stage #(.DELAY(PERI_DLY)) u_peri (
    .clk_i(sys_clk_i), .arst_ni(cgen_rst_no), .rel_no(peri_rst_no));

  rst_seq_stage #(.DELAY(CORE_DLY)) u_core (
    .clk_i(sys_clk_i), .arst_ni(peri_rst_no), .rel_no(core_rst_no));

  rst_seq_sync u_tap (
    .clk_i(osc_clk_i), .arst_ni(por_ni), .rel_no(tap_rst_no));

  rst_seq_cause u_cause (
    .clk_i(osc_clk_i), .por_ni(por_ni), .src_i(req),
    .cgen_rel_ni(cgen_rst_no), .cause_o(cause));

  assign cause_o = cause;

  assert_cgen_after_xpor_R3: assert property (@(posedge osc_clk_i) disable iff (!por_ni)
    cgen_rst_no |-> xpor_rst_no);

  assert_peri_after_cgen_R4: assert property (@(posedge sys_clk_i) disable iff (!por_ni)
    peri_rst_no |-> cgen_rst_no);

  assert_core_after_peri_R5: assert property (@(posedge sys_clk_i) disable iff (!por_ni)
    core_rst_no |-> peri_rst_no);

  assert_xpor_por_only_R6: assert property (@(posedge osc_clk_i) disable iff (!por_ni)
    xpor_rst_no |=> xpor_rst_no);

  assert_tap_por_only_R7: assert property (@(posedge osc_clk_i) disable iff (!por_ni)
    tap_rst_no |=> tap_rst_no);
endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  typedef struct packed {
    logic [2:0] src;    // 0 por, 1 ext, 2 sw, 3 tmo, 4 lor
    logic [3:0] half;   // system clock half period, even ns
    logic [2:0] cause;  // expected cause code
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 4'd2, 3'd0}, '{3'd1, 4'd2, 3'd1}, '{3'd2, 4'd4, 3'd2},
    '{3'd3, 4'd6, 3'd3}, '{3'd4, 4'd2, 3'd4}, '{3'd0, 4'd6, 3'd0},
    '{3'd1, 4'd6, 3'd1}, '{3'd2, 4'd2, 3'd2}
  };

  logic osc_clk = 1'b0, sys_clk = 1'b0;
  int   sys_half = 4;
  logic por_n = 1'b1, ext_n = 1'b1, sw = 1'b0, tmo = 1'b0, lor = 1'b0;
  logic xpor_n, cgen_n, peri_n, core_n, tap_n;
  logic [2:0] cause;

  int checks = 0, fails = 0;
  int osc_cnt = 0, sys_cnt = 0;
  int xpor_at = -1, cgen_at = -1, cgen_sys = -1, peri_at = -1, core_at = -1, tap_at = -1;
  int xpor_falls = 0, tap_falls = 0;
  bit finished = 1'b0;

  rst_seq_top dut_i (
    .osc_clk_i(osc_clk), .sys_clk_i(sys_clk), .por_ni(por_n), .ext_rst_ni(ext_n),
    .sw_rst_i(sw), .wdt_tmo_i(tmo), .wdt_lor_i(lor),
    .xpor_rst_no(xpor_n), .cgen_rst_no(cgen_n), .peri_rst_no(peri_n),
    .core_rst_no(core_n), .tap_rst_no(tap_n), .cause_o(cause));

  always #5 osc_clk = ~osc_clk;
  initial forever #(sys_half) sys_clk = ~sys_clk;

  always @(posedge osc_clk) osc_cnt++;
  always @(posedge sys_clk) sys_cnt++;
  always @(posedge xpor_n) xpor_at = osc_cnt;
  always @(posedge cgen_n) begin cgen_at = osc_cnt; cgen_sys = sys_cnt; end
  always @(posedge peri_n) peri_at = sys_cnt;
  always @(posedge core_n) core_at = sys_cnt;
  always @(posedge tap_n) tap_at = osc_cnt;
  always @(negedge xpor_n) xpor_falls++;
  always @(negedge tap_n) tap_falls++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_marks();
    xpor_at = -1; cgen_at = -1; cgen_sys = -1; peri_at = -1; core_at = -1; tap_at = -1;
  endtask

  task automatic pulse_sync(input int src);
    @(negedge sys_clk);
    case (src)
      2: sw = 1'b1;
      3: tmo = 1'b1;
      default: lor = 1'b1;
    endcase
    #1;
    chk("R6 cgen low", cgen_n, 0);
    chk("R6 core low", core_n, 0);
    chk("R6 xpor kept", xpor_n, 1);
    @(negedge sys_clk);
    sw = 1'b0; tmo = 1'b0; lor = 1'b0;
  endtask

  task automatic check_tail();
    chk("R4 peri count", peri_at, cgen_sys + 32);
    chk("R5 core count", core_at, peri_at + 32);
  endtask

  task automatic run_vec(input int src, input int half, input int exp_cause);
    int xf, tf, rel, prev;
    sys_half = half;
    @(negedge osc_clk);
    xf = xpor_falls; tf = tap_falls; prev = cause;
    clr_marks();
    if (src == 0) begin
      por_n = 1'b0; #1;
      chk("R1 xpor low", xpor_n, 0);
      chk("R1 tap low", tap_n, 0);
      chk("R1 peri low", peri_n, 0);
      repeat (3) @(negedge osc_clk);
      por_n = 1'b1; rel = osc_cnt;
    end else if (src == 1) begin
      ext_n = 1'b0; #1;
      chk("R6 peri low", peri_n, 0);
      chk("R6 tap kept", tap_n, 1);
      chk("R9 cause held", cause, prev);
      repeat (3) @(negedge osc_clk);
      ext_n = 1'b1; rel = osc_cnt;
    end else begin
      pulse_sync(src);
      rel = osc_cnt;
    end
    wait (core_n === 1'b1);
    repeat (3) @(negedge osc_clk);
    if (src == 0) begin
      chk("R2 xpor count", xpor_at, rel + 64);
      chk("R3 cgen count after xpor", cgen_at, xpor_at + 32);
      chk("R7 tap count", tap_at, rel + 2);
    end else begin
      chk("R3 cgen count", cgen_at, rel + 32);
      chk("R6 xpor untouched", xpor_falls, xf);
      chk("R7 tap untouched", tap_falls, tf);
    end
    check_tail();
    chk("R9 cause", cause, exp_cause);
  endtask

  initial begin : watchdog
    #500000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int rel;
    #1 por_n = 1'b0;
    #2;
    // R1 reset state
    chk("R1 xpor", xpor_n, 0);
    chk("R1 cgen", cgen_n, 0);
    chk("R1 core", core_n, 0);
    chk("R1 tap", tap_n, 0);
    chk("R1 cause", cause, 0);

    foreach (VEC[i]) run_vec(int'(VEC[i].src), int'(VEC[i].half), int'(VEC[i].cause));

    // R8: power-on reset again during the stretched count
    sys_half = 4;
    @(negedge osc_clk);
    clr_marks();
    por_n = 1'b0;
    repeat (2) @(negedge osc_clk);
    por_n = 1'b1;
    repeat (20) @(negedge osc_clk);
    por_n = 1'b0; #1;
    chk("R8 xpor restarted low", xpor_n, 0);
    repeat (2) @(negedge osc_clk);
    por_n = 1'b1; rel = osc_cnt;
    wait (core_n === 1'b1);
    repeat (2) @(negedge osc_clk);
    chk("R8 xpor count from new release", xpor_at, rel + 64);
    check_tail();

    // R8: watchdog pulse while the peripheral stage counts
    @(negedge osc_clk);
    clr_marks();
    por_n = 1'b0;
    repeat (2) @(negedge osc_clk);
    por_n = 1'b1;
    wait (cgen_n === 1'b1);
    repeat (5) @(negedge sys_clk);
    pulse_sync(3);
    rel = osc_cnt;
    chk("R8 peri dropped", peri_n, 0);
    wait (core_n === 1'b1);
    repeat (3) @(negedge osc_clk);
    chk("R8 cgen recount", cgen_at, rel + 32);
    check_tail();
    chk("R9 cause tmo", cause, 3);

    // R3/R9: external pin held low across the stretched-POR release
    sys_half = 6;
    @(negedge osc_clk);
    clr_marks();
    por_n = 1'b0; ext_n = 1'b0;
    repeat (2) @(negedge osc_clk);
    por_n = 1'b1;
    wait (xpor_n === 1'b1);
    repeat (10) @(negedge osc_clk);
    chk("R3 cgen held by pin", cgen_n, 0);
    ext_n = 1'b1; rel = osc_cnt;
    wait (core_n === 1'b1);
    repeat (3) @(negedge osc_clk);
    chk("R3 cgen after last source", cgen_at, rel + 32);
    chk("R9 cause ext after por", cause, 1);

    // R9 precedence: software and loss-of-reference together give 4
    sys_half = 2;
    @(negedge osc_clk);
    clr_marks();
    @(negedge sys_clk);
    sw = 1'b1; lor = 1'b1;
    @(negedge sys_clk);
    sw = 1'b0; lor = 1'b0;
    wait (core_n === 1'b1);
    repeat (3) @(negedge osc_clk);
    chk("R9 lor over sw", cause, 4);

    // R9 precedence: external pin over watchdog time-out gives 1
    @(negedge osc_clk);
    ext_n = 1'b0;
    @(negedge sys_clk);
    tmo = 1'b1;
    @(negedge sys_clk);
    tmo = 1'b0;
    repeat (2) @(negedge osc_clk);
    ext_n = 1'b1;
    wait (core_n === 1'b1);
    repeat (3) @(negedge osc_clk);
    chk("R9 ext over tmo", cause, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule